// File: doc/BRIEF.md
# Wide Pixel Port Serializer

This block sits in the fast pixel-clock domain in front of a triple video DAC. An upstream frame buffer presents eight 24-bit RGB pixels side by side on one 192-bit word. The block sends that word out again as a stream of one pixel per clock: three 8-bit colour channels and a valid flag.

To pace the upstream side, the block divides the pixel clock by eight and drives the result out as a load-out strobe. The frame buffer returns the strobe after a fixed round trip as load-in. On the rising edge of load-in the block takes a new group. A holding buffer keeps that group until the pixel shifter finishes the current one. The buffer hands the group over in the same cycle that the last pixel leaves, so consecutive groups leave with no gap. A delay line after the shifter makes the time from capture to output the same for every slot.

The output side has no ready signal, because the DAC cannot hold the stream back. Every valid pixel is consumed on the clock it appears. The only flow control is the load-out pacing: a group that arrives late produces idle cycles and is never a reason to stall. Valid/ready is therefore reduced to valid only, and there is no back-pressure.

Top module: `pixel_serializer`

## Requirements
- R1: After reset is released, load_out is high for the first four clock edges and low for the next four, and this eight-cycle pattern repeats (50% duty, divide-by-eight).
- R2: A group is captured at the clock edge where load_in is first sampled 1 after being sampled 0. grp_data is sampled only at that edge, and its value at any other edge has no effect on the output.
- R3: Pixel slot k of grp_data (k = 0 for pixel A up to 7 for pixel H) occupies bits [24k+23:24k]. Within a slot, red is bits [23:16], green is [15:8] and blue is [7:0]. Pixels leave in the order A, B, C, …, H on consecutive clocks.
- R4: Pixel A of a group appears on the outputs, with pix_valid high, right after the 19th clock edge that follows its capture edge. Pixel slot k appears after edge 19+k.
- R5: If a group is captured eight clocks after the previous capture, its pixel A follows the previous group's pixel H on the very next clock, with no idle cycle.
- R6: If no group is waiting when pixel H leaves, pix_valid is low and all three channels are zero for each idle cycle. A group captured later still keeps the latency of R4.
- R7: While rst_n is low, load_out, pix_valid and all channels are zero. pix_valid stays low for at least 19 cycles after reset is released.
- R8: Holding load_in high for several edges captures only once; no extra pixels are produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_out | output | 1 | Divide-by-eight strobe to the upstream source |
| load_in | input | 1 | Returned strobe; its rising edge captures a group |
| grp_data | input | 192 | Eight packed 24-bit pixels, slot A in the low bits |
| pix_r | output | 8 | Red channel of the current pixel |
| pix_g | output | 8 | Green channel of the current pixel |
| pix_b | output | 8 | Blue channel of the current pixel |
| pix_valid | output | 1 | High when the channels carry a pixel |

## Verification
Each kind of internal fault leaves its own mark at the pins:
- A slot counter that drifts would repeat or drop a pixel. The numbered slot field then goes wrong within the first group, 19 to 27 cycles after its capture.
- A holding buffer that hands over late would open a one-cycle hole between groups. A buffer that re-captures while load-in stays high would emit a group twice. Either fault shows on the second group.
- A delay line of the wrong length moves every pixel by the same amount. A fault in the divider breaks the four-high/four-low pattern of load-out within eight cycles.

// File: rtl/pixser_pkg.sv
package pixser_pkg;
  localparam int CH_W  = 8;
  localparam int PIX_W = 3 * CH_W;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb_t;
endpackage

// File: rtl/load_strobe_gen.sv
module load_strobe_gen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic load_out
);
  localparam int CW = $clog2(DIV);
  localparam logic [CW-1:0] HALF = CW'(DIV / 2);
  localparam logic [CW-1:0] RUN_LAST = CW'(DIV / 2 - 1);

  logic [CW-1:0] cnt_q;
  logic          out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      out_q <= (cnt_q < HALF);
    end
  end

  assign load_out = out_q;

  // checker state: length of the current level run
  logic          prev_q;
  logic          seen_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      seen_q <= 1'b0;
      run_q  <= '0;
    end else begin
      prev_q <= out_q;
      if (out_q != prev_q) begin
        seen_q <= 1'b1;
        run_q  <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  AST_LOADOUT_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && (out_q != prev_q)) |-> (run_q == RUN_LAST)); // R1
endmodule

// File: rtl/group_capture.sv
module group_capture #(
  parameter int W = 192
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_in,
  input  logic [W-1:0] grp_data,
  input  logic         take,
  output logic [W-1:0] hold_data,
  output logic         hold_full
);
  logic         li_q;
  logic         rise;
  logic [W-1:0] buf_q;
  logic         full_q;

  assign rise = load_in & ~li_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      li_q   <= 1'b0;
      buf_q  <= '0;
      full_q <= 1'b0;
    end else begin
      li_q <= load_in;
      if (rise) begin
        buf_q  <= grp_data;
        full_q <= 1'b1;
      end else if (take) begin
        full_q <= 1'b0;
      end
    end
  end

  assign hold_data = buf_q;
  assign hold_full = full_q;

  AST_TAKE_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full_q); // R2
endmodule

// File: rtl/pixel_shifter.sv
module pixel_shifter #(
  parameter int LANES = 8,
  parameter int PIX_W = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LANES*PIX_W-1:0] hold_data,
  input  logic                   hold_full,
  output logic                   take,
  output logic [PIX_W-1:0]       pix_out,
  output logic                   pix_vld
);
  localparam int GW = LANES * PIX_W;
  localparam int SW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [SW-1:0] LAST = SW'(LANES - 1);

  logic [GW-1:0] sreg_q;
  logic [SW-1:0] slot_q;
  logic          busy_q;

  assign take = hold_full && (!busy_q || (slot_q == LAST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg_q <= '0;
      slot_q <= '0;
      busy_q <= 1'b0;
    end else if (take) begin
      sreg_q <= hold_data;
      slot_q <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      sreg_q <= {{PIX_W{1'b0}}, sreg_q[GW-1:PIX_W]};
      slot_q <= slot_q + 1'b1;
      if (slot_q == LAST) busy_q <= 1'b0;
    end
  end

  assign pix_out = busy_q ? sreg_q[PIX_W-1:0] : '0;
  assign pix_vld = busy_q;

  AST_ALL_SLOTS_SENT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (slot_q != LAST)) |=> busy_q); // R3
  AST_NO_GAP_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (slot_q == LAST) && hold_full) |=> (busy_q && (slot_q == '0))); // R5
endmodule

// File: rtl/latency_line.sv
module latency_line #(
  parameter int DEPTH = 18,
  parameter int W     = 25
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign dout = din;
    end else begin : g_pipe
      logic [W-1:0] stg_q [DEPTH];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) stg_q[i] <= '0;
        end else begin
          stg_q[0] <= din;
          for (int i = 1; i < DEPTH; i++) stg_q[i] <= stg_q[i-1];
        end
      end
      assign dout = stg_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/pixel_serializer.sv
module pixel_serializer
  import pixser_pkg::*;
#(
  parameter int LANES   = 8,
  parameter int LATENCY = 19
) (
  input  logic                   clk,
  input  logic                   rst_n,
  output logic                   load_out,
  input  logic                   load_in,
  input  logic [LANES*PIX_W-1:0] grp_data,
  output logic [CH_W-1:0]        pix_r,
  output logic [CH_W-1:0]        pix_g,
  output logic [CH_W-1:0]        pix_b,
  output logic                   pix_valid
);
  localparam int GW  = LANES * PIX_W;
  localparam int DLY = LATENCY - 1;
  localparam int TW  = $clog2(LATENCY + 1);
  localparam logic [TW-1:0] LAT_C = TW'(LATENCY);

  logic [GW-1:0]    hold_data;
  logic             hold_full;
  logic             take;
  logic [PIX_W-1:0] sh_pix;
  logic             sh_vld;
  logic [PIX_W:0]   line_out;
  rgb_t             px;

  load_strobe_gen #(.DIV(LANES)) u_strobe (
    .clk(clk), .rst_n(rst_n), .load_out(load_out)
  );

  group_capture #(.W(GW)) u_capture (
    .clk(clk), .rst_n(rst_n), .load_in(load_in), .grp_data(grp_data),
    .take(take), .hold_data(hold_data), .hold_full(hold_full)
  );

  pixel_shifter #(.LANES(LANES), .PIX_W(PIX_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .hold_data(hold_data), .hold_full(hold_full),
    .take(take), .pix_out(sh_pix), .pix_vld(sh_vld)
  );

  latency_line #(.DEPTH(DLY), .W(PIX_W + 1)) u_line (
    .clk(clk), .rst_n(rst_n), .din({sh_vld, sh_pix}), .dout(line_out)
  );

  assign px        = rgb_t'(line_out[PIX_W-1:0]);
  assign pix_r     = px.r;
  assign pix_g     = px.g;
  assign pix_b     = px.b;
  assign pix_valid = line_out[PIX_W];

  // checker: cycles since reset release, saturating
  logic [TW-1:0] since_q;
  always_ff @(posedge clk) begin
    if (!rst_n) since_q <= '0;
    else if (since_q != LAT_C) since_q <= since_q + 1'b1;
  end

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q < LAT_C) |-> !pix_valid); // R7
  AST_IDLE_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> (line_out[PIX_W-1:0] == '0)); // R6
endmodule

// File: tb/pixel_serializer_tb.sv
module pixel_serializer_tb;
  localparam int LANES = 8;
  localparam int LAT   = 19;
  localparam int RT    = 3;
  localparam int NCYC  = 900;

  logic         clk;
  logic         rst_n;
  logic         load_in;
  logic [191:0] grp_data;
  logic         load_out;
  logic [7:0]   pix_r, pix_g, pix_b;
  logic         pix_valid;

  pixel_serializer #(.LANES(LANES), .LATENCY(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .load_out(load_out), .load_in(load_in),
    .grp_data(grp_data), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
    .pix_valid(pix_valid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  logic [24:0] exp_w [64];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // expected pixel for slot k of group g (R3 field layout)
  function automatic logic [23:0] pixel_of(input int g, input int k, input logic [7:0] rnd);
    if (g == 2) return 24'hFFFFFF;
    if (g == 3) return 24'h000000;
    return {g[7:0], 4'(k), 4'hA, rnd};
  endfunction

  initial begin
    logic [RT-1:0] hist;
    logic          echo_prev;
    int            g;
    int            rises;
    int unsigned   seed;
    seed = $urandom(32'h5EED);
    for (int i = 0; i < 64; i++) exp_w[i] = '0;
    rst_n = 1'b0; load_in = 1'b0; grp_data = '0;
    hist = '0; echo_prev = 1'b0; g = 0; rises = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      grp_data = {6{$urandom}};
      check("R7 reset", {load_out, pix_valid, pix_r, pix_g, pix_b}, 32'h0);
    end
    grp_data = '0;
    rst_n = 1'b1;
    for (int n = 1; n <= NCYC; n++) begin
      @(negedge clk);
      // R1: divide-by-eight, four high then four low
      check("R1 load_out", {31'h0, load_out}, {31'h0, (((n - 1) % 8) < 4)});
      // R2 R3 R4 R5 when a pixel is due; R6 R7 R8 when idle
      if (exp_w[n % 64][24])
        check("R2 R3 R4 R5 pixel", {7'h0, pix_valid, pix_r, pix_g, pix_b}, {7'h0, exp_w[n % 64]});
      else
        check("R6 R7 R8 idle", {7'h0, pix_valid, pix_r, pix_g, pix_b}, 32'h0);
      exp_w[n % 64] = '0;
      hist = {hist[RT-2:0], load_out};
      if (hist[RT-1] && !echo_prev) begin
        rises++;
        if (rises == 6 || (rises > 30 && ($urandom % 6) == 0)) begin
          load_in = 1'b0;                       // R6: withheld group
          grp_data = {6{$urandom}};
        end else begin
          for (int k = 0; k < LANES; k++) begin
            logic [23:0] p;
            p = pixel_of(g, k, 8'($urandom));
            grp_data[24*k +: 24] = p;
            exp_w[(n + 1 + LAT + k) % 64] = {1'b1, p};
          end
          load_in = 1'b1;
          g++;
        end
      end else begin
        if (!hist[RT-1]) load_in = 1'b0;
        grp_data = {6{$urandom}};               // R2: ignored off the capture edge
      end
      echo_prev = hist[RT-1];
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule